// File: doc/BRIEF.md
# Approach Vehicle Demand Qualifier

This block serves one sensed approach of a signalised junction. It counts the vehicles reported by a loop detector and shows the lowest bits of that count on a small binary LED display. Once enough vehicles are queued and the queue has waited long enough, it raises a demand flag. The phase sequencer reads the flag to decide whether to serve the approach. When it gives the approach a green, the sequencer pulses a clear, which empties the queue and restarts the block.

The detector input is asynchronous. It passes through a two-stage synchroniser, and only its rising edge is counted, so a vehicle that sits on the loop counts once. The wait timer counts a one-pulse-per-second tick.

A small state machine holds the queue condition:
- `ST_EMPTY` means no vehicle since the last clear. The timer is held at zero.
- `ST_QUEUED` means at least one vehicle is waiting. The timer runs on the tick.
- `ST_DEMAND` means the demand flag is up.

The transitions are:
- `EMPTY->QUEUED` on the first counted arrival.
- `QUEUED->DEMAND` when the wait has elapsed and the count is at or above the threshold.
- `QUEUED->EMPTY` and `DEMAND->EMPTY` on a clear.
- In every other case the state holds.

The vehicle threshold is an input. Typical values are 2 for a turn lane and 4 for a through approach.

Top module: `approach_demand_qual`

## Requirements
- R1: Each rising edge of the synchronised arrival input adds exactly one to the queue count. An input held high for many cycles counts once.
- R2: The count keeps rising after it reaches the threshold, for as long as no clear arrives.
- R3: The count saturates at 15 and does not wrap to 0.
- R4: `demand` is never raised while the count is below `veh_threshold`. A threshold of 0 behaves like a threshold of 1.
- R5: `demand` is raised only after WAIT_SEC (default 10) `sec_tick` pulses have been seen in `ST_QUEUED`, which is entered on the first arrival after a clear. Ticks that arrive while the queue is empty are ignored.
- R6: Once raised, `demand` stays high until `green_clr` is asserted.
- R7: A cycle with `green_clr` high sets the count to 0, lowers `demand` and returns the machine to `ST_EMPTY`. An arrival edge in that same cycle is discarded.
- R8: `count_led` always equals bits [2:0] of the queue count.
- R9: After reset the count is 0, `count_led` is 0 and `demand` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| arrive_raw | input | 1 | Asynchronous vehicle detector level |
| green_clr | input | 1 | Pulse: this approach has been given green |
| veh_threshold | input | 4 | Vehicles needed before demand may rise |
| count_led | output | 3 | Binary display of the low count bits |
| demand | output | 1 | Qualified demand flag |

## Verification
Four properties are checked on every cycle:
- The count never falls except on a clear.
- The count is held at its maximum.
- Demand rises only with the count at or above the threshold and the wait timer complete.
- Demand holds until a clear, and a clear always empties the count.

Only the bench scenarios can show the rest. These are the exact ten-second boundary, that ticks before the first vehicle are ignored, that a long detector pulse counts once, and that a clear beats an arrival in the same cycle. They also show the displayed bits after saturation and random mixes of arrivals and ticks against an order-independent model.

// File: rtl/adq_pkg.sv
package adq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_QUEUED = 2'd1,
        ST_DEMAND = 2'd2
    } adq_state_t;

endpackage

// File: rtl/adq_arrival_edge.sv
module adq_arrival_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= raw_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/adq_vehicle_counter.sv
module adq_vehicle_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adq_wait_timer.sv
module adq_wait_timer #(
    parameter int WAIT_SEC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic elapsed
);
    localparam int TW = $clog2(WAIT_SEC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(WAIT_SEC);

    logic [TW-1:0] secs_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                              secs_q <= '0;
        else if (restart)                        secs_q <= '0;
        else if (run && tick && secs_q != LIMIT) secs_q <= secs_q + 1'b1;
    end

    assign elapsed = (secs_q == LIMIT);
endmodule

// File: rtl/approach_demand_qual.sv
module approach_demand_qual
    import adq_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int LED_W       = 3,
    parameter int WAIT_SEC    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             arrive_raw,
    input  logic             green_clr,
    input  logic [CNT_W-1:0] veh_threshold,
    output logic [LED_W-1:0] count_led,
    output logic             demand
);
    adq_state_t       state_q, state_d;
    logic             arr_pulse;
    logic [CNT_W-1:0] veh_cnt;
    logic             wait_done;
    logic             enough_veh;

    adq_arrival_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (arrive_raw),
        .rise_pulse (arr_pulse)
    );

    adq_vehicle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (green_clr),
        .inc   (arr_pulse),
        .cnt   (veh_cnt)
    );

    adq_wait_timer #(.WAIT_SEC(WAIT_SEC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_EMPTY),
        .run     (state_q == ST_QUEUED),
        .tick    (sec_tick),
        .elapsed (wait_done)
    );

    assign enough_veh = (veh_cnt >= veh_threshold);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (!green_clr && arr_pulse) state_d = ST_QUEUED;
            end
            ST_QUEUED: begin
                if (green_clr)                     state_d = ST_EMPTY;
                else if (wait_done && enough_veh)  state_d = ST_DEMAND;
            end
            ST_DEMAND: begin
                if (green_clr) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) demand <= 1'b0;
        else        demand <= (state_d == ST_DEMAND);
    end

    assign count_led = veh_cnt[LED_W-1:0];
endmodule

// File: rtl/adq_checker.sv
module adq_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             green_clr,
    input logic [CNT_W-1:0] veh_threshold,
    input logic [CNT_W-1:0] veh_cnt,
    input logic             wait_done,
    input logic             demand
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !green_clr |=> veh_cnt >= $past(veh_cnt));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!green_clr && veh_cnt == CNT_MAX) |=> veh_cnt == CNT_MAX);

    p_thresh_met_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(demand) |-> veh_cnt >= veh_threshold);

    p_wait_met_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(demand) |-> wait_done);

    p_demand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (demand && !green_clr) |=> demand);

    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        green_clr |=> (veh_cnt == '0 && !demand));
endmodule

bind approach_demand_qual adq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .green_clr     (green_clr),
    .veh_threshold (veh_threshold),
    .veh_cnt       (veh_cnt),
    .wait_done     (wait_done),
    .demand        (demand)
);

// File: tb/tb_approach_demand_qual.sv
`timescale 1ns/1ps
module tb_approach_demand_qual;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       arrive_raw = 1'b0;
    logic       green_clr = 1'b0;
    logic [3:0] veh_threshold = 4'd2;
    logic [2:0] count_led;
    logic       demand;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    approach_demand_qual dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_tick      (sec_tick),
        .arrive_raw    (arrive_raw),
        .green_clr     (green_clr),
        .veh_threshold (veh_threshold),
        .count_led     (count_led),
        .demand        (demand)
    );

    function automatic int exp_count(int n);
        return (n > 15) ? 15 : n;
    endfunction

    function automatic bit exp_demand(int n, int thr, int t);
        int eff;
        eff = (thr < 1) ? 1 : thr;
        return (n >= 1) && (t >= 10) && (exp_count(n) >= eff);
    endfunction

    task automatic check(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic arrive(int hold);
        @(negedge clk) arrive_raw = 1'b1;
        repeat (hold) @(negedge clk);
        arrive_raw = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear();
        @(negedge clk) green_clr = 1'b1;
        @(negedge clk) green_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(count_led, 0, "R9 reset count");
        check(demand, 0, "R9 reset demand");

        // R1: long pulse counts once
        arrive(12);
        check(count_led, 1, "R1 long pulse");
        arrive(3);
        check(count_led, 2, "R1 second arrival");
        clear();

        // R5: ticks before first arrival ignored, exact 10 s boundary
        veh_threshold = 4'd2;
        repeat (5) tick();
        arrive(3);
        arrive(3);
        repeat (9) tick();
        check(demand, 0, "R5 nine seconds");
        tick();
        check(demand, 1, "R5 ten seconds");
        // R2: counting continues past threshold, R6: demand held
        arrive(3);
        arrive(3);
        check(count_led, 4, "R2 past threshold");
        repeat (20) @(negedge clk);
        check(demand, 1, "R6 held");
        clear();
        check(count_led, 0, "R7 clear count");
        check(demand, 0, "R7 clear demand");

        // R4: waited long enough but too few vehicles
        veh_threshold = 4'd4;
        arrive(3); arrive(3); arrive(3);
        repeat (12) tick();
        check(demand, 0, "R4 below threshold");
        arrive(3);
        check(demand, 1, "R4 threshold reached");
        clear();

        // R3 and R8: saturation seen on display
        for (int i = 0; i < 17; i++) arrive(3);
        check(count_led, 7, "R3 saturate at 15");
        arrive(3);
        check(count_led, 7, "R3 stays at 15");
        clear();
        for (int i = 0; i < 5; i++) arrive(3);
        check(count_led, 5, "R8 low bits");
        clear();

        // R7: clear coincides with an arrival edge
        @(negedge clk) arrive_raw = 1'b1;
        @(negedge clk);
        @(negedge clk) green_clr = 1'b1;
        @(negedge clk) green_clr = 1'b0;
        repeat (4) @(negedge clk);
        check(count_led, 0, "R7 clear beats arrival");
        arrive_raw = 1'b0;
        repeat (4) @(negedge clk);
        repeat (11) tick();
        check(demand, 0, "R7 state empty after clash");
        clear();

        // Random mixes
        for (int r = 0; r < 40; r++) begin
            int n, thr, t, pre, an, tn;
            n   = $urandom_range(0, 17);
            thr = $urandom_range(0, 6);
            t   = $urandom_range(0, 14);
            pre = $urandom_range(0, 3);
            veh_threshold = 4'(thr);
            repeat (pre) tick();
            an = 0;
            tn = 0;
            if (n > 0) begin
                arrive($urandom_range(1, 6));
                an = 1;
            end else begin
                tn = t;
                repeat (t) tick();
            end
            while (an < n || tn < t) begin
                if (an < n && (tn >= t || $urandom_range(0, 1) == 1)) begin
                    arrive($urandom_range(1, 6));
                    an++;
                end else begin
                    tick();
                    tn++;
                end
            end
            check(count_led, exp_count(n) % 8, "R1 R8 random count");
            check(demand, exp_demand(n, thr, t), "R4 R5 random demand");
            clear();
            check(demand, 0, "R7 random clear");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule